// File: doc/BRIEF.md
# Linked-Table Trace Address Translator

This block sits between a trace writer and memory and turns each input write address into a physical address. Software places a chain of 4 KB tables in memory. Each table maps one 1 MB window of input space to 256 data pages of 4 KB. Table slot 511 holds the link to the following table and slot 510 holds the link to the preceding one, so the chain can be walked in either direction and may be closed into a ring. Software programs a table base and a 1 MB aligned input base, then enables the block in translate mode or in pass-through mode.

A request carries one input address. In translate mode the block subtracts the input base and works out the target window. It then moves a table cursor toward that window one link read per step and reads the data entry for the page. It returns the page address joined with the in-page offset, or an error flag. The cursor stays where the last walk left it, so nearby requests need no link reads. Only one translation is in flight at a time. Table entries are fetched through a simple request/response read port.

Top module: `lt_xlat`

## Requirements
- R1: After reset the enable and mode registers read 0, the status register reads 1 (ready), req_ready_o is low, and resp_valid_o and mem_req_o are low.
- R2: Register word addresses are 0 enable (bit 0), 1 mode (bit 0: 1 translate, 0 pass-through), 2 status (bit 0 ready, read-only), 3 identity (read-only, low 6 bits give the physical address width, 40 by default), 4/5 table base low/high, 6/7 input base low/high. The table base low word reads back with bits 11:0 cleared. The input base low word reads back with bits 19:0 cleared. Writes to addresses 2 and 3 have no effect.
- R3: While enable is 0, req_ready_o is low and a request gets no response.
- R4: In pass-through mode an accepted request returns its own address with no error in the cycle after acceptance, and no table read is issued.
- R5: In translate mode, with offset = address − input base, a request in the cursor's window reads the entry at cursor table + 8·offset[19:12]. The response comes two cycles after acceptance and carries {entry[63:12], offset[11:0]}.
- R6: An entry is good only when bit 0 is 1 and bits 11:1 are 0. A bad data entry gives resp_err_o = 1 with resp_addr_o = 0. This includes the unused tail slots of the last table.
- R7: When the target window is above the cursor, the block reads the link at cursor table + 0xFF8, moves to the linked table and raises the window by one. Each step takes two cycles, and steps repeat until the windows match. A ring chain lets windows past the last table wrap to the first.
- R8: When the target window is below the cursor, the block reads links at cursor table + 0xFF0 and lowers the window by one per step. The cursor is kept between requests.
- R9: A bad link entry ends the walk with an error two cycles after that link read was issued. No further reads are made, and the cursor stays on the last good table.
- R10: In translate mode an address below the input base returns an error in the cycle after acceptance, with no table read.
- R11: From acceptance until the response of a translate walk, req_ready_o and the status ready bit are low. Both are high in the response cycle.
- R12: A write to the enable register or to any base register puts the cursor back on the table base at window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address (read and write) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 64 | Input address to translate |
| req_ready_o | output | 1 | Block can accept a request |
| resp_valid_o | output | 1 | Response valid, one cycle per request |
| resp_addr_o | output | 64 | Translated (or forwarded) address |
| resp_err_o | output | 1 | Translation failed |
| mem_req_o | output | 1 | Table read request, one-cycle pulse |
| mem_addr_o | output | 64 | Table entry address |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 64 | Table entry |

## Verification
The hardest state to reach is a cursor far from the target with a broken link somewhere on the path. Reaching it needs an earlier walk to park the cursor, and then a request whose walk must cross several links, one of them invalid. The stimulus builds a three-table ring with a short last table and a corrupted data slot, plus a separate table whose forward link is empty. It then orders requests so that walks go forward, wrap through the ring, return backward across three links, and finally hit the empty link after a base rewrite. Each response's cycle and every read address are predicted from a behavioural cursor in the bench.

// File: rtl/lt_xlat_pkg.sv
package lt_xlat_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned PAGE_SH = 12;
  localparam int unsigned WIN_SH  = 20;
  localparam int unsigned ENT_SH  = 3;
  localparam int unsigned WIN_W   = ADDR_W - WIN_SH;
  localparam int unsigned IDX_W   = WIN_SH - PAGE_SH;
  localparam int unsigned SLOT_W  = PAGE_SH - ENT_SH;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned REG_DW  = 32;

  localparam logic [SLOT_W-1:0] SLOT_PREV = SLOT_W'(510);
  localparam logic [SLOT_W-1:0] SLOT_NEXT = SLOT_W'(511);

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_MODE  = 3'd1,
    RA_STAT  = 3'd2,
    RA_ID    = 3'd3,
    RA_TB_LO = 3'd4,
    RA_TB_HI = 3'd5,
    RA_IB_LO = 3'd6,
    RA_IB_HI = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {WS_IDLE, WS_ISSUE, WS_WAIT} walk_st_e;
  typedef enum logic [1:0] {RK_DATA, RK_NEXT, RK_PREV} rd_kind_e;
endpackage

// File: rtl/lt_xlat_entry.sv
module lt_xlat_entry
  import lt_xlat_pkg::*;
(
  input  logic [ADDR_W-1:0]       raw_i,
  output logic                    ok_o,
  output logic [ADDR_W-1:PAGE_SH] page_o
);
  // valid flag set and reserved bits clear
  assign ok_o   = raw_i[0] && (raw_i[PAGE_SH-1:1] == '0);
  assign page_o = raw_i[ADDR_W-1:PAGE_SH];
endmodule

// File: rtl/lt_xlat_regs.sv
module lt_xlat_regs
  import lt_xlat_pkg::*;
#(
  parameter int unsigned PA_BITS = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [REG_AW-1:0]       reg_addr_i,
  input  logic [REG_DW-1:0]       reg_wdata_i,
  output logic [REG_DW-1:0]       reg_rdata_o,
  input  logic                    ready_i,
  output logic                    en_o,
  output logic                    xlate_o,
  output logic [ADDR_W-1:PAGE_SH] tbase_o,
  output logic [ADDR_W-1:0]       ibase_o,
  output logic                    cursor_rst_o
);
  localparam int unsigned ID_W = 6;
  localparam logic [ID_W-1:0] ID_VAL = ID_W'(PA_BITS);

  logic                    en_q, xl_q, crst_q;
  logic [ADDR_W-1:PAGE_SH] tb_q;
  logic [ADDR_W-1:WIN_SH]  ib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      xl_q   <= 1'b0;
      crst_q <= 1'b0;
      tb_q   <= '0;
      ib_q   <= '0;
    end else begin
      crst_q <= 1'b0;
      if (reg_we_i) begin
        case (reg_addr_e'(reg_addr_i))
          RA_CTRL:  begin en_q <= reg_wdata_i[0]; crst_q <= 1'b1; end
          RA_MODE:  xl_q <= reg_wdata_i[0];
          RA_TB_LO: begin tb_q[REG_DW-1:PAGE_SH] <= reg_wdata_i[REG_DW-1:PAGE_SH]; crst_q <= 1'b1; end
          RA_TB_HI: begin tb_q[ADDR_W-1:REG_DW] <= reg_wdata_i; crst_q <= 1'b1; end
          RA_IB_LO: begin ib_q[REG_DW-1:WIN_SH] <= reg_wdata_i[REG_DW-1:WIN_SH]; crst_q <= 1'b1; end
          RA_IB_HI: begin ib_q[ADDR_W-1:REG_DW] <= reg_wdata_i; crst_q <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_e'(reg_addr_i))
      RA_CTRL:  reg_rdata_o = {{(REG_DW-1){1'b0}}, en_q};
      RA_MODE:  reg_rdata_o = {{(REG_DW-1){1'b0}}, xl_q};
      RA_STAT:  reg_rdata_o = {{(REG_DW-1){1'b0}}, ready_i};
      RA_ID:    reg_rdata_o = {{(REG_DW-ID_W){1'b0}}, ID_VAL};
      RA_TB_LO: reg_rdata_o = {tb_q[REG_DW-1:PAGE_SH], {PAGE_SH{1'b0}}};
      RA_TB_HI: reg_rdata_o = tb_q[ADDR_W-1:REG_DW];
      RA_IB_LO: reg_rdata_o = {ib_q[REG_DW-1:WIN_SH], {WIN_SH{1'b0}}};
      RA_IB_HI: reg_rdata_o = ib_q[ADDR_W-1:REG_DW];
      default:  reg_rdata_o = '0;
    endcase
  end

  assign en_o         = en_q;
  assign xlate_o      = xl_q;
  assign tbase_o      = tb_q;
  assign ibase_o      = {ib_q, {WIN_SH{1'b0}}};
  assign cursor_rst_o = crst_q;
endmodule

// File: rtl/lt_xlat_walker.sv
module lt_xlat_walker
  import lt_xlat_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    xlate_i,
  input  logic [ADDR_W-1:PAGE_SH] tbase_i,
  input  logic [ADDR_W-1:0]       ibase_i,
  input  logic                    cursor_rst_i,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  output logic                    req_ready_o,
  output logic                    resp_valid_o,
  output logic [ADDR_W-1:0]       resp_addr_o,
  output logic                    resp_err_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [ADDR_W-1:0]       mem_rdata_i,
  output logic                    idle_o
);
  localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

  walk_st_e                st_q;
  rd_kind_e                kind_q, kind_d;
  logic [ADDR_W-1:PAGE_SH] cur_tbl_q;
  logic [WIN_W-1:0]        cur_win_q, tgt_win_q;
  logic [WIN_SH-1:0]       off_q;
  logic [ADDR_W-1:0]       off_full;
  logic                    below, accept;
  logic                    ent_ok;
  logic [ADDR_W-1:PAGE_SH] ent_page;
  logic [SLOT_W-1:0]       slot;
  logic                    rv_q, err_q;
  logic [ADDR_W-1:0]       ra_q;

  lt_xlat_entry u_entry (
    .raw_i  (mem_rdata_i),
    .ok_o   (ent_ok),
    .page_o (ent_page)
  );

  assign off_full    = req_addr_i - ibase_i;
  assign below       = req_addr_i < ibase_i;
  assign idle_o      = (st_q == WS_IDLE);
  assign req_ready_o = en_i && idle_o;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    if (cur_win_q == tgt_win_q)     kind_d = RK_DATA;
    else if (tgt_win_q > cur_win_q) kind_d = RK_NEXT;
    else                            kind_d = RK_PREV;
  end

  always_comb begin
    case (kind_d)
      RK_NEXT: slot = SLOT_NEXT;
      RK_PREV: slot = SLOT_PREV;
      default: slot = {1'b0, off_q[WIN_SH-1:PAGE_SH]};
    endcase
  end

  // tables are page aligned, so the slot is concatenated, not added
  assign mem_req_o  = (st_q == WS_ISSUE);
  assign mem_addr_o = {cur_tbl_q, slot, {ENT_SH{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= WS_IDLE;
      kind_q    <= RK_DATA;
      cur_tbl_q <= '0;
      cur_win_q <= '0;
      tgt_win_q <= '0;
      off_q     <= '0;
      rv_q      <= 1'b0;
      err_q     <= 1'b0;
      ra_q      <= '0;
    end else begin
      rv_q <= 1'b0;
      case (st_q)
        WS_IDLE: if (accept) begin
          if (!xlate_i) begin
            rv_q  <= 1'b1;
            err_q <= 1'b0;
            ra_q  <= req_addr_i;
          end else if (below) begin
            rv_q  <= 1'b1;
            err_q <= 1'b1;
            ra_q  <= '0;
          end else begin
            tgt_win_q <= off_full[ADDR_W-1:WIN_SH];
            off_q     <= off_full[WIN_SH-1:0];
            st_q      <= WS_ISSUE;
          end
        end
        WS_ISSUE: begin
          kind_q <= kind_d;
          st_q   <= WS_WAIT;
        end
        WS_WAIT: if (mem_rvalid_i) begin
          if (kind_q == RK_DATA) begin
            rv_q  <= 1'b1;
            err_q <= !ent_ok;
            ra_q  <= ent_ok ? {ent_page, off_q[PAGE_SH-1:0]} : '0;
            st_q  <= WS_IDLE;
          end else if (ent_ok) begin
            cur_tbl_q <= ent_page;
            cur_win_q <= (kind_q == RK_NEXT) ? cur_win_q + WIN_ONE : cur_win_q - WIN_ONE;
            st_q      <= WS_ISSUE;
          end else begin
            rv_q  <= 1'b1;
            err_q <= 1'b1;
            ra_q  <= '0;
            st_q  <= WS_IDLE;
          end
        end
        default: st_q <= WS_IDLE;
      endcase
      if (cursor_rst_i) begin
        cur_tbl_q <= tbase_i;
        cur_win_q <= '0;
      end
    end
  end

  assign resp_valid_o = rv_q;
  assign resp_err_o   = err_q;
  assign resp_addr_o  = ra_q;
endmodule

// File: rtl/lt_xlat.sv
module lt_xlat
  import lt_xlat_pkg::*;
#(
  parameter int unsigned PA_BITS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [ADDR_W-1:0] resp_addr_o,
  output logic              resp_err_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  logic                    en, xlate, walk_idle, cursor_rst;
  logic [ADDR_W-1:PAGE_SH] tbase;
  logic [ADDR_W-1:0]       ibase;

  lt_xlat_regs #(.PA_BITS(PA_BITS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .ready_i      (walk_idle),
    .en_o         (en),
    .xlate_o      (xlate),
    .tbase_o      (tbase),
    .ibase_o      (ibase),
    .cursor_rst_o (cursor_rst)
  );

  lt_xlat_walker u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .xlate_i      (xlate),
    .tbase_i      (tbase),
    .ibase_i      (ibase),
    .cursor_rst_i (cursor_rst),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_ready_o  (req_ready_o),
    .resp_valid_o (resp_valid_o),
    .resp_addr_o  (resp_addr_o),
    .resp_err_o   (resp_err_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .idle_o       (walk_idle)
  );
endmodule

// File: rtl/lt_xlat_chk.sv
module lt_xlat_chk
  import lt_xlat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              xlate_i,
  input logic              idle_i,
  input logic              resp_valid_i,
  input logic              resp_err_i,
  input logic [ADDR_W-1:0] resp_addr_i,
  input logic              mem_req_i
);
  a_r11_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |=> !mem_req_i);

  a_r11_busy_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |=> !idle_i);

  a_r4_no_read_in_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> xlate_i);

  a_r6_err_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_i && resp_err_i) |-> (resp_addr_i == '0));

  a_r3_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && idle_i) |=> !resp_valid_i);
endmodule

bind lt_xlat lt_xlat_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en),
  .xlate_i      (xlate),
  .idle_i       (walk_idle),
  .resp_valid_i (resp_valid_o),
  .resp_err_i   (resp_err_o),
  .resp_addr_i  (resp_addr_o),
  .mem_req_i    (mem_req_o)
);

// File: tb/lt_xlat_bench.sv
module lt_xlat_bench;
  import lt_xlat_pkg::*;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [63:0] T0 = 64'h8000_0000, T1 = 64'h8000_1000, T2 = 64'h8000_5000;
  localparam logic [63:0] T3 = 64'h9000_0000, IB = 64'h1_0000_0000, DB = 64'h4_0000_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic req_valid_i = 1'b0, req_ready_o, resp_valid_o, resp_err_o, mem_req_o;
  logic [63:0] req_addr_i = '0, resp_addr_o, mem_addr_o;
  logic mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  lt_xlat u_lt_xlat (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_q [$];
  int vec = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_tbl, m_tb, m_ib;
  longint m_win;
  logic pend = 1'b0;
  logic [63:0] paddr, popd;

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  function automatic bit good(input logic [63:0] e);
    return e[0] && (e[11:1] == 11'h0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // table memory with one cycle of read latency
  always @(negedge clk_i) begin
    mem_rvalid_i <= 1'b0;
    if (pend) begin
      mem_rvalid_i <= 1'b1;
      mem_rdata_i  <= rd(paddr);
      pend         <= 1'b0;
    end
    if (mem_req_o) begin
      pend  <= 1'b1;
      paddr <= mem_addr_o;
      if (exp_q.size() == 0) chk(1'b0, "R4/R10 unexpected table read", mem_addr_o, 64'h0);
      else begin
        popd = exp_q.pop_front();
        chk(mem_addr_o == popd, "R5/R7/R8 table read address", mem_addr_o, popd);
      end
    end
  end

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    case (a)
      3'd4: m_tb[31:0]  = {d[31:12], 12'h0};
      3'd5: m_tb[63:32] = d;
      3'd6: m_ib[31:0]  = {d[31:20], 20'h0};
      3'd7: m_ib[63:32] = d;
      default: ;
    endcase
    if (a == 3'd0 || a >= 3'd4) begin
      m_tbl = m_tb;
      m_win = 0;
    end
    @(negedge clk_i);
  endtask

  task automatic xl(input logic [63:0] a, input bit tr, input string tag);
    logic [63:0] off, la, e, exp_a;
    longint tgt;
    int steps = 0, lat;
    bit fail = 0, exp_e;
    logic [31:0] st;
    if (!tr) begin
      lat = 0; exp_e = 0; exp_a = a;
    end else if (a < m_ib) begin
      lat = 0; exp_e = 1; exp_a = 0;
    end else begin
      off = a - m_ib;
      tgt = longint'(off >> 20);
      while (m_win != tgt && !fail) begin
        la = m_tbl + ((tgt > m_win) ? 64'hFF8 : 64'hFF0);
        exp_q.push_back(la);
        e = rd(la);
        steps++;
        if (!good(e)) fail = 1;
        else begin
          m_tbl = {e[63:12], 12'h0};
          m_win = m_win + ((tgt > m_win) ? 1 : -1);
        end
      end
      if (fail) begin
        lat = 2 * steps; exp_e = 1; exp_a = 0;
      end else begin
        la = m_tbl + ((off >> 12) & 64'hFF) * 8;
        exp_q.push_back(la);
        e = rd(la);
        lat = 2 + 2 * steps;
        exp_e = !good(e);
        exp_a = good(e) ? {e[63:12], off[11:0]} : 64'h0;
      end
    end
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    @(posedge clk_i);
    for (int n = 0; n <= lat; n++) begin
      @(negedge clk_i);
      if (n == 0) req_valid_i = 1'b0;
      chk(resp_valid_o == (n == lat), {tag, " response cycle"}, 64'(resp_valid_o), 64'(n == lat));
      chk(req_ready_o == (n >= lat), "R11 req_ready during walk", 64'(req_ready_o), 64'(n >= lat));
      if (n == 1 && lat > 1) begin
        rreg(3'd2, st);
        chk(st == 0, "R11 status ready low while walking", 64'(st), 64'h0);
      end
      if (n == lat) begin
        chk(resp_err_o == exp_e, {tag, " error flag"}, 64'(resp_err_o), 64'(exp_e));
        chk(resp_addr_o == exp_a, {tag, " address"}, resp_addr_o, exp_a);
      end
    end
    @(negedge clk_i);
    chk(exp_q.size() == 0, {tag, " all reads issued"}, 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    m_tb = 0; m_ib = 0; m_tbl = 0; m_win = 0;
    for (int t = 0; t < 3; t++) begin
      logic [63:0] tb;
      tb = (t == 0) ? T0 : (t == 1) ? T1 : T2;
      for (int i = 0; i < ((t == 2) ? 100 : 256); i++)
        mem[tb + 64'(i) * 8] = DB + (64'(t) << 20) + (64'(i) << 12) + 64'h1;
    end
    mem[T1 + 5 * 8] = DB + 64'h5000;           // valid bit clear
    mem[T0 + 7 * 8] = DB + 64'h7000 + 64'h11;  // reserved bit set
    mem[T0 + 64'hFF0] = T2 | 64'h1; mem[T0 + 64'hFF8] = T1 | 64'h1;
    mem[T1 + 64'hFF0] = T0 | 64'h1; mem[T1 + 64'hFF8] = T2 | 64'h1;
    mem[T2 + 64'hFF0] = T1 | 64'h1; mem[T2 + 64'hFF8] = T0 | 64'h1;
    mem[T3] = 64'h7_7777_7000 | 64'h1;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    rreg(3'd0, d); chk(d == 0, "R1 enable reset", 64'(d), 64'h0);
    rreg(3'd1, d); chk(d == 0, "R1 mode reset", 64'(d), 64'h0);
    rreg(3'd2, d); chk(d == 1, "R1 status ready", 64'(d), 64'h1);
    chk(!req_ready_o && !resp_valid_o && !mem_req_o, "R1 outputs idle",
        64'({req_ready_o, resp_valid_o, mem_req_o}), 64'h0);
    // R2
    wreg(3'd4, 32'h8000_0ABC); rreg(3'd4, d); chk(d == 32'h8000_0000, "R2 table base low", 64'(d), 64'h8000_0000);
    wreg(3'd5, 32'h1); rreg(3'd5, d); chk(d == 1, "R2 table base high", 64'(d), 64'h1);
    wreg(3'd5, 32'h0);
    wreg(3'd6, 32'h0012_3456); rreg(3'd6, d); chk(d == 32'h0010_0000, "R2 input base low", 64'(d), 64'h0010_0000);
    wreg(3'd6, 32'h0);
    wreg(3'd7, 32'h1); rreg(3'd7, d); chk(d == 1, "R2 input base high", 64'(d), 64'h1);
    rreg(3'd3, d); chk(d[5:0] == 6'd40, "R2 identity width", 64'(d), 64'd40);
    wreg(3'd2, 32'h0); rreg(3'd2, d); chk(d == 1, "R2 status read-only", 64'(d), 64'h1);
    wreg(3'd3, 32'h0); rreg(3'd3, d); chk(d == 40, "R2 identity read-only", 64'(d), 64'd40);
    // R3
    @(negedge clk_i); req_valid_i = 1'b1; req_addr_i = 64'h1234;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk_i);
      chk(!req_ready_o && !resp_valid_o, "R3 disabled ignores request",
          64'({req_ready_o, resp_valid_o}), 64'h0);
    end
    req_valid_i = 1'b0;
    // R4
    wreg(3'd0, 32'h1);
    xl(64'h1234_5678_9ABC_DEF0, 1'b0, "R4 pass-through");
    xl(64'h0000_0000_0000_0042, 1'b0, "R4 pass-through low");
    wreg(3'd1, 32'h1);
    // R5 .. R8
    xl(IB + 64'h123,       1'b1, "R5 first page");
    xl(IB + 64'hF_F456,    1'b1, "R5 last slot");
    xl(IB + 64'h7ABC,      1'b1, "R6 reserved bit");
    xl(IB + 64'h20_3ABC,   1'b1, "R7 forward two links");
    xl(IB + 64'h20_4000,   1'b1, "R8 cursor kept");
    xl(IB + 64'h30_0010,   1'b1, "R7 ring wrap");
    xl(IB + 64'h1000,      1'b1, "R8 backward three links");
    xl(IB + 64'h10_5000,   1'b1, "R6 invalid data entry");
    xl(IB + 64'h29_6000,   1'b1, "R6 unused tail slot");
    xl(IB - 64'h10,        1'b1, "R10 below base");
    // R9, R12
    wreg(3'd4, T3[31:0]);
    xl(IB + 64'h10_0000,   1'b1, "R9 empty link");
    xl(IB + 64'h40,        1'b1, "R9 cursor stays");
    wreg(3'd4, T0[31:0]);
    xl(IB + 64'h10_0000,   1'b1, "R12 base write resets cursor");
    wreg(3'd0, 32'h1);
    xl(IB + 64'h2000,      1'b1, "R12 enable write resets cursor");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule